// File: doc/BRIEF.md
# Timed Instruction Sequencer with Duration Sweep

This block is a per-channel control core that plays a stored list of timed output instructions back to back. Each instruction selects one of four behaviours: stay quiet, set a DC level code, enable an oscillator tone at a given phase, or request a number of samples. Each one lasts an exact number of clock cycles. The whole list runs a programmed number of times. After each pass, every instruction may lengthen itself by its own fixed step. A single instruction list can therefore sweep a delay or a pulse width across the iterations of one run.

A host fills the instruction memory and the control registers through a simple write port that carries an address and a data word per write, in the manner of an AXI4-Lite write channel. A launch strobe that several cores share starts them all in the same clock edge. The core reports busy and done, drives a one-cycle marker at the start of flagged instructions, and presents the level, tone and sample controls to datapaths outside the block.

Instruction word (bit positions fixed): [2:0] opcode, [3] arm flag, [19:4] value (level code, phase or sample count), [20+DUR_W-1:20] base duration in cycles, next 16 bits duration step. The host writes a word as two 32-bit halves. Write addresses are word addresses. When bit ADDR_W-1 is 0, the write goes to the instruction memory: entry index = addr[ADDR_W-2:1], and addr[0] selects the half (0 = bits 31:0, 1 = the bits above). When bit ADDR_W-1 is 1, addr[1:0] selects a register: 0 = list length, 1 = iteration count, 2 = control, where writing bit 0 = 1 performs a soft reset.

Top module: `seq_core`

## Requirements
- R1: After rst_n is released, busy, done, arm_pulse, tone_en and smp_active are 0 and level_code, tone_phase and smp_count are 0.
- R2: A launch accepted at a clock edge makes busy 1 in the following cycle, and that cycle already shows the outputs of entry 0.
- R3: Each instruction occupies exactly its effective duration in cycles, with a duration of 0 treated as 1. The next instruction follows with no gap cycle, so a run lasts the sum of all effective durations.
- R4: Opcode 1 (level) sets level_code to its value at the instruction start. level_code keeps that value until another level instruction, a soft reset or rst_n changes it, including after the run ends.
- R5: Opcode 2 (play) drives tone_en = 1 and tone_phase = value for the whole instruction.
- R6: Opcode 3 (sample) drives smp_active = 1 and smp_count = value for the whole instruction.
- R7: arm_pulse is 1 for exactly the first cycle of every instruction whose arm bit is 1, and is 0 in all other cycles.
- R8: After the last instruction of the last iteration, busy falls and done becomes 1. While busy is 0, tone_en, smp_active and arm_pulse are 0.
- R9: In iteration k, counted from 0, an instruction lasts base + k*step cycles. Both the accumulated step and the sum saturate at 2^DUR_W-1.
- R10: A launch received while busy is 1 has no effect on the run in progress.
- R11: Accumulated steps persist into later launches. A soft reset ends any run, clears busy, done, level_code, the iteration counter and all accumulated steps, so the next launch uses base durations.
- R12: A launch is ignored while the list length or the iteration count is 0.
- R13: Opcode 0 and opcodes 4 to 7 behave as idle: no tone, no sample, and level_code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Host word address |
| wr_data | input | 32 | Host write data |
| launch | input | 1 | Shared start strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| arm_pulse | output | 1 | First cycle of an armed instruction |
| level_code | output | 16 | Held DC level code |
| tone_en | output | 1 | Oscillator tone enable |
| tone_phase | output | 16 | Tone phase during play |
| smp_active | output | 1 | Sample window active |
| smp_count | output | 16 | Requested samples for the window |

## Verification
The hardest state to reach from the ports is an iteration boundary in a one-entry list with a nonzero step. The entry that just ended must update its own accumulated step in the same edge where it is fetched again. A one-entry vector with a step of 2 over four iterations reaches this case, and the run length it gives exposes any stale read. Saturation needs an effective duration beyond the counter range, which is impractical at full width. The bench therefore builds the core with a 12-bit duration counter and sweeps a 4000-cycle entry by 200 per pass.

// File: rtl/seq_pkg.sv
// Shared constants for the timed sequencer: opcode codes and the fixed
// field positions inside an instruction word. Assumes a 3-bit opcode,
// 16-bit value and 16-bit step; the duration width is set per instance.
package seq_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_LEVEL  = 3'd1,
        OP_PLAY   = 3'd2,
        OP_SAMPLE = 3'd3
    } seq_op_e;

    localparam int OP_W    = 3;
    localparam int ARM_BIT = 3;
    localparam int VAL_LSB = 4;
    localparam int VAL_W   = 16;
    localparam int DUR_LSB = VAL_LSB + VAL_W;
    localparam int INC_W   = 16;
    localparam int HOST_W  = 32;
endpackage

// File: rtl/seq_sat_add.sv
// Saturating adder: y = min(a + b, 2^W - 1). Operand b may be wider or
// narrower than W; it is treated as unsigned.
module seq_sat_add #(
    parameter int W  = 24,
    parameter int BW = 16
) (
    input  logic [W-1:0]  a,
    input  logic [BW-1:0] b,
    output logic [W-1:0]  y
);
    localparam int SW = ((W > BW) ? W : BW) + 1;

    logic [SW-1:0] sum;

    // Add in a width that cannot wrap, then clamp to the W-bit range.
    always_comb begin
        sum = SW'(a) + SW'(b);
        y   = (sum > SW'({W{1'b1}})) ? {W{1'b1}} : sum[W-1:0];
    end
endmodule

// File: rtl/seq_prog_store.sv
// Host-facing storage: instruction memory written as two 32-bit halves,
// plus list length, iteration count and a soft reset pulse. Assumes word
// addressing with the top address bit choosing memory (0) or registers (1).
// One combinational read port serves the sequencer.
module seq_prog_store
    import seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 60,
    parameter int ITER_W = 16,
    localparam int PW     = $clog2(DEPTH),
    localparam int ADDR_W = PW + 2,
    localparam int LEN_W  = PW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HOST_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [LEN_W-1:0]  prog_len,
    output logic [ITER_W-1:0] iter_cnt,
    output logic              soft_rst
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic              is_reg;
    logic [PW-1:0]     wr_idx;
    logic              unused_bits;

    assign is_reg      = wr_addr[ADDR_W-1];
    assign wr_idx      = wr_addr[ADDR_W-2:1];
    assign rd_word     = mem[rd_idx];
    assign unused_bits = ^{wr_data[HOST_W-1:1]};

    // Instruction memory: store the addressed half of the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && !is_reg) begin
            if (!wr_addr[0]) mem[wr_idx][HOST_W-1:0] <= wr_data;
            else             mem[wr_idx][WORD_W-1:HOST_W] <= wr_data[WORD_W-HOST_W-1:0];
        end
    end

    // Control registers and the one-cycle soft reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_len <= '0;
            iter_cnt <= '0;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= wr_en && is_reg && (wr_addr[1:0] == 2'd2) && wr_data[0];
            if (wr_en && is_reg && wr_addr[1:0] == 2'd0) prog_len <= wr_data[LEN_W-1:0];
            if (wr_en && is_reg && wr_addr[1:0] == 2'd1) iter_cnt <= wr_data[ITER_W-1:0];
        end
    end
endmodule

// File: rtl/seq_core.sv
// Timed instruction sequencer. Runs entries 0..len-1 back to back, each for
// its effective duration, repeating the list iter_cnt times. Each entry keeps
// a saturating accumulated step that grows when the entry completes. The next
// entry is addressed ahead of time (npc) so that it loads in the last cycle
// of the current one with no gap. Assumes durations of 0 mean 1 cycle.
module seq_core
    import seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DUR_W  = 24,
    parameter int ITER_W = 16,
    localparam int PW     = $clog2(DEPTH),
    localparam int ADDR_W = PW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              launch,
    output logic              busy,
    output logic              done,
    output logic              arm_pulse,
    output logic [15:0]       level_code,
    output logic              tone_en,
    output logic [15:0]       tone_phase,
    output logic              smp_active,
    output logic [15:0]       smp_count
);
    localparam int LEN_W  = PW + 1;
    localparam int WORD_W = DUR_LSB + DUR_W + INC_W;
    localparam int INC_LSB = DUR_LSB + DUR_W;

    logic [LEN_W-1:0]  prog_len;
    logic [ITER_W-1:0] iter_cnt;
    logic              soft_rst;
    logic [WORD_W-1:0] nword;

    logic              busy_q, done_q, arm_q;
    logic [PW-1:0]     pc_q, npc;
    logic [ITER_W-1:0] iter_q;
    logic [DUR_W-1:0]  cnt_q;
    logic [OP_W-1:0]   cur_op;
    logic [VAL_W-1:0]  cur_val, lvl_q;
    logic [INC_W-1:0]  cur_inc;
    logic [DUR_W-1:0]  acc_q [DEPTH];

    logic              last_cyc, last_instr, last_iter, start, finish, advance, load;
    logic [DUR_W-1:0]  acc_upd, acc_sel, dsum, ndur;

    seq_prog_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ITER_W(ITER_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(npc), .rd_word(nword), .prog_len(prog_len), .iter_cnt(iter_cnt),
        .soft_rst(soft_rst)
    );

    // Step accumulation for the entry that is ending.
    seq_sat_add #(.W(DUR_W), .BW(INC_W)) u_acc (.a(acc_q[pc_q]), .b(cur_inc), .y(acc_upd));
    // Effective duration of the entry about to load.
    seq_sat_add #(.W(DUR_W), .BW(DUR_W)) u_dur (.a(nword[DUR_LSB +: DUR_W]), .b(acc_sel), .y(dsum));

    // Sequencing decisions for the current cycle.
    always_comb begin
        last_cyc   = busy_q && (cnt_q == DUR_W'(1));
        last_instr = ({1'b0, pc_q} == prog_len - LEN_W'(1));
        last_iter  = (iter_q == iter_cnt - ITER_W'(1));
        start      = launch && !busy_q && !soft_rst && (prog_len != '0) && (iter_cnt != '0);
        finish     = last_cyc && last_instr && last_iter;
        advance    = last_cyc && !finish && !soft_rst;
        load       = start || advance;
        npc        = (start || last_instr) ? '0 : pc_q + PW'(1);
        acc_sel    = (advance && npc == pc_q) ? acc_upd : acc_q[npc];
        ndur       = (dsum == '0) ? DUR_W'(1) : dsum;
    end

    // Run control: launch, instruction loading, countdown and completion.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            arm_q   <= 1'b0;
            pc_q    <= '0;
            iter_q  <= '0;
            cnt_q   <= '0;
            cur_op  <= '0;
            cur_val <= '0;
            cur_inc <= '0;
            lvl_q   <= '0;
        end else begin
            arm_q <= load && nword[ARM_BIT];
            if (load) begin
                cur_op  <= nword[OP_W-1:0];
                cur_val <= nword[VAL_LSB +: VAL_W];
                cur_inc <= nword[INC_LSB +: INC_W];
                cnt_q   <= ndur;
                pc_q    <= npc;
                if (nword[OP_W-1:0] == OP_LEVEL) lvl_q <= nword[VAL_LSB +: VAL_W];
            end else if (busy_q) begin
                cnt_q <= cnt_q - DUR_W'(1);
            end
            if (start) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;
                iter_q <= '0;
            end else if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else if (advance && last_instr) begin
                iter_q <= iter_q + ITER_W'(1);
            end
        end
    end

    // Per-entry accumulated step, updated as each entry completes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int i = 0; i < DEPTH; i++) acc_q[i] <= '0;
        end else if (last_cyc) begin
            acc_q[pc_q] <= acc_upd;
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign arm_pulse  = arm_q;
    assign level_code = lvl_q;
    assign tone_en    = busy_q && (cur_op == OP_PLAY);
    assign tone_phase = tone_en ? cur_val : '0;
    assign smp_active = busy_q && (cur_op == OP_SAMPLE);
    assign smp_count  = smp_active ? cur_val : '0;
endmodule

// File: rtl/seq_core_chk.sv
// Property checker for seq_core, attached by bind. Observes ports plus the
// soft reset pulse, countdown and program counter.
module seq_core_chk #(
    parameter int PW    = 4,
    parameter int DUR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             launch,
    input logic             busy,
    input logic             done,
    input logic             arm_pulse,
    input logic             tone_en,
    input logic             smp_active,
    input logic [15:0]      level_code,
    input logic             soft_rst,
    input logic [DUR_W-1:0] cnt_q,
    input logic [PW-1:0]    pc_q
);
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));                                             // R3
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !soft_rst && !launch) |=> $stable(level_code));            // R4
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                     // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tone_en && !smp_active && !arm_pulse));                  // R8
    AST_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && launch && cnt_q > DUR_W'(1) && !soft_rst) |=> (busy && $stable(pc_q))); // R10
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tone_en, smp_active}));                                    // R13
endmodule

bind seq_core seq_core_chk #(.PW(PW), .DUR_W(DUR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .done(done),
    .arm_pulse(arm_pulse), .tone_en(tone_en), .smp_active(smp_active),
    .level_code(level_code), .soft_rst(soft_rst), .cnt_q(cnt_q), .pc_q(pc_q)
);

// File: tb/sim_seq_core.sv
// Self-checking bench: a vector table of one-entry programs, then directed
// tests for reset, gapless multi-entry timing, launch while busy, soft reset
// and zero length or zero iteration counts. Duration width is reduced to 12.
module sim_seq_core;
    localparam int DEPTH  = 16;
    localparam int DW     = 12;
    localparam int AW     = $clog2(DEPTH) + 2;
    localparam int WW     = 36 + DW;
    localparam longint MAXD = (1 << DW) - 1;
    localparam int REG_BASE = 1 << (AW - 1);

    typedef struct packed {
        logic [2:0]  op;
        logic        arm;
        logic [15:0] val;
        logic [11:0] base;
        logic [15:0] inc;
        logic [15:0] iters;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{3'd1, 1'b1, 16'hBEEF, 12'd5,    16'd0,   16'd3},
        '{3'd2, 1'b0, 16'h1234, 12'd0,    16'd2,   16'd4},
        '{3'd3, 1'b1, 16'd1000, 12'd10,   16'd3,   16'd2},
        '{3'd5, 1'b0, 16'd7,    12'd4,    16'd0,   16'd1},
        '{3'd1, 1'b0, 16'd1,    12'd4000, 16'd200, 16'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          launch = 1'b0;
    logic          busy, done, arm_pulse, tone_en, smp_active;
    logic [15:0]   level_code, tone_phase, smp_count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    seq_core #(.DEPTH(DEPTH), .DUR_W(DW), .ITER_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .launch(launch), .busy(busy), .done(done), .arm_pulse(arm_pulse),
        .level_code(level_code), .tone_en(tone_en), .tone_phase(tone_phase),
        .smp_active(smp_active), .smp_count(smp_count)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic host_wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_entry(input int idx, input logic [2:0] op, input logic arm,
                             input logic [15:0] val, input logic [DW-1:0] base,
                             input logic [15:0] inc);
        logic [WW-1:0] w;
        w = {inc, base, val, arm, op};
        host_wr(idx * 2, w[31:0]);
        host_wr(idx * 2 + 1, 32'(w[WW-1:32]));
    endtask

    task automatic soft_reset();
        host_wr(REG_BASE + 2, 32'd1);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Leaves the bench at the first negedge after the launch edge.
    task automatic fire();
        @(negedge clk);
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic longint eff_dur(input longint base, input longint inc, input int k);
        longint a;
        longint d;
        a = longint'(k) * inc;
        if (a > MAXD) a = MAXD;
        d = base + a;
        if (d > MAXD) d = MAXD;
        if (d == 0) d = 1;
        return d;
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 arm", arm_pulse, 0);
        chk("R1 tone", tone_en, 0);
        chk("R1 smp", smp_active, 0);
        chk("R1 level", level_code, 0);

        // Vector table: one-entry programs, varied opcode, step and count.
        for (int v = 0; v < 5; v++) begin
            longint tot;
            soft_reset();
            put_entry(0, VECS[v].op, VECS[v].arm, VECS[v].val, VECS[v].base, VECS[v].inc);
            host_wr(REG_BASE + 0, 32'd1);
            host_wr(REG_BASE + 1, 32'(VECS[v].iters));
            fire();
            chk("R2 busy after launch", busy, 1);
            chk("R7 arm first cycle", arm_pulse, VECS[v].arm);
            chk("R5 tone_en", tone_en, VECS[v].op == 3'd2);
            chk("R5 tone_phase", tone_phase, (VECS[v].op == 3'd2) ? VECS[v].val : 0);
            chk("R6 smp_active", smp_active, VECS[v].op == 3'd3);
            chk("R6 smp_count", smp_count, (VECS[v].op == 3'd3) ? VECS[v].val : 0);
            chk("R4 R13 level", level_code, (VECS[v].op == 3'd1) ? VECS[v].val : 0);
            tot = 0;
            for (int k = 0; k < int'(VECS[v].iters); k++)
                tot += eff_dur(VECS[v].base, VECS[v].inc, k);
            count_busy(n);
            chk("R3 R9 run length", n, tot);
            chk("R8 done", done, 1);
            chk("R4 level held after run", level_code, (VECS[v].op == 3'd1) ? VECS[v].val : 0);
        end

        // Gapless three-entry trace over two iterations, per cycle.
        soft_reset();
        put_entry(0, 3'd1, 1'b1, 16'd5,      DW'(3), 16'd0);
        put_entry(1, 3'd2, 1'b0, 16'h1234,   DW'(2), 16'd1);
        put_entry(2, 3'd3, 1'b0, 16'd7,      DW'(0), 16'd0);
        host_wr(REG_BASE + 0, 32'd3);
        host_wr(REG_BASE + 1, 32'd2);
        fire();
        begin
            int bad;
            int bases [3] = '{3, 2, 0};
            int incs  [3] = '{0, 1, 0};
            int ops   [3] = '{1, 2, 3};
            bad = 0;
            for (int it = 0; it < 2; it++) begin
                for (int i = 0; i < 3; i++) begin
                    longint d;
                    d = eff_dur(bases[i], incs[i], it);
                    for (int c = 0; c < d; c++) begin
                        if (busy !== 1'b1 || tone_en !== (ops[i] == 2) ||
                            smp_active !== (ops[i] == 3) || level_code !== 16'd5 ||
                            arm_pulse !== (c == 0 && i == 0) ||
                            (ops[i] == 2 && tone_phase !== 16'h1234) ||
                            (ops[i] == 3 && smp_count !== 16'd7)) bad++;
                        @(negedge clk);
                    end
                end
            end
            chk("R3 R5 R6 R7 gapless trace mismatches", bad, 0);
            chk("R8 trace busy low", busy, 0);
            chk("R8 trace done", done, 1);
        end

        // R10: launch in the middle of a run does not restart it.
        soft_reset();
        put_entry(0, 3'd0, 1'b0, 16'd0, DW'(50), 16'd0);
        host_wr(REG_BASE + 0, 32'd1);
        host_wr(REG_BASE + 1, 32'd1);
        fire();
        repeat (9) @(negedge clk);
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        count_busy(n);
        chk("R10 run length with extra launch", n, 40);

        // R11: steps persist across launches; soft reset clears them.
        soft_reset();
        put_entry(0, 3'd0, 1'b0, 16'd0, DW'(5), 16'd4);
        host_wr(REG_BASE + 0, 32'd1);
        host_wr(REG_BASE + 1, 32'd2);
        fire();
        count_busy(n);
        chk("R11 first run", n, 14);
        fire();
        count_busy(n);
        chk("R11 second run keeps steps", n, 30);
        soft_reset();
        chk("R11 done cleared", done, 0);
        fire();
        count_busy(n);
        chk("R11 after soft reset", n, 14);
        fire();
        repeat (3) @(negedge clk);
        soft_reset();
        chk("R11 soft reset aborts", busy, 0);

        // R12: zero length or zero iteration count blocks launch.
        host_wr(REG_BASE + 0, 32'd0);
        fire();
        chk("R12 zero length", busy, 0);
        host_wr(REG_BASE + 0, 32'd1);
        host_wr(REG_BASE + 1, 32'd0);
        fire();
        chk("R12 zero iterations", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule